// File: doc/BRIEF.md
# Floating-Point Status Register and Exception Resolver

This block keeps the status word of a floating-point unit. The word holds the rounding mode, two trap enables, two sticky exception flags, a 3-bit trap code and a scratch field that software may use as it likes. Arithmetic logic elsewhere raises raw exception flags at the end of each operation. This block reduces those flags to a single trap code and sets the sticky flags. It also tells the result path three things: whether the processor must take a trap, whether the result must be withheld, and whether the result must be replaced by zero.

The status word is written whole from the low half of a 32-bit operand, and it is read back zero-extended to 32 bits. A start strobe clears the trap code before each new operation. An evaluate strobe carries the flags of the finished operation. The decision outputs are combinational. They are valid in the cycle of the evaluate strobe and use the enable bits held in the register at that moment. The register updates at the following clock edge.

Top module: `fpx_status_unit`

## Requirements
- R1: While reset is asserted and after it is released, the status word is all zero, so the rounding mode is 00 (nearest-even) and both traps are disabled.
- R2: A load takes bits 15:0 of `ld_data` into the status word and ignores bits 31:16. `round_mode` always shows bits 8:7 of the word. `store_data` is the word with 16 zero bits above it.
- R3: When `op_start` is high and neither load nor evaluate is high, bits 2:0 (trap code) clear at the next edge and every other bit keeps its value.
- R4: In the `exc_flags` vector, bit 0 is underflow, bit 1 overflow, bit 2 divide-by-zero, bit 3 invalid and bit 4 inexact. An evaluate writes bits 2:0 with the code of the lowest-numbered flag that is set: 1 underflow, 2 overflow, 3 divide-by-zero, 5 invalid, 6 inexact. It writes 0 when no flag is set. Code 7 never appears.
- R5: An underflow sets bit 4 (sticky). If bit 3 (underflow enable) is set it raises `quit`; otherwise it raises `zero_result` and does not trap.
- R6: Overflow or divide-by-zero, when it is the recorded exception, always raises `quit`.
- R7: An invalid operation, when recorded, writes code 5 and raises neither `quit` nor `zero_result`.
- R8: An inexact result, when recorded, sets bit 6 (sticky) and raises `quit` only when bit 5 (inexact enable) is set.
- R9: `suppress` equals `quit` in every cycle. All three decision outputs are low whenever `exc_valid` is low, whatever the flags.
- R10: When `illegal` is high during an evaluate, code 4 is written and `quit` is raised. The arithmetic flags are ignored, and bits 4 and 6 keep their values.
- R11: Bits 4 and 6 stay set through later operations, start strobes and clean evaluates. Only a load changes them.
- R12: A load in the same cycle as an evaluate or a start strobe wins: the word becomes the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start of an operation; clears the trap code |
| exc_valid | input | 1 | Flags of a finished operation are present |
| exc_flags | input | 5 | Raw flags: 0 underflow, 1 overflow, 2 divide-by-zero, 3 invalid, 4 inexact |
| illegal | input | 1 | The operation's opcode is not implemented |
| ld_en | input | 1 | Load the status word |
| ld_data | input | 32 | Load operand; low 16 bits are used |
| status_q | output | 16 | Current status word |
| store_data | output | 32 | Status word zero-extended for a store |
| round_mode | output | 2 | 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| quit | output | 1 | Trap request for the current evaluate |
| suppress | output | 1 | Withhold the result of the current evaluate |
| zero_result | output | 1 | Replace the result with zero (masked underflow) |

## Verification
The bench walks all 32 flag combinations under each of the four enable settings. A resolver with a wrong priority order would record, for example, inexact where overflow was present, or trap on an invalid operation. It checks that a masked underflow zeroes the result without trapping, and that an enabled underflow traps instead. A design that confused these would either trap on a flush-to-zero or deliver a denormal result. It checks that the sticky bits survive clean evaluates and are ignored by an illegal opcode. It checks that a load colliding with an evaluate or a start strobe wins, and that a load drops the upper operand half. A wrong merge order in the register would leave trap codes or stray sticky bits behind.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  // field positions inside the status word
  localparam int TT_LSB  = 0;
  localparam int TT_W    = 3;
  localparam int UEN_BIT = 3;
  localparam int UF_BIT  = 4;
  localparam int IEN_BIT = 5;
  localparam int IF_BIT  = 6;
  localparam int RM_LSB  = 7;
  localparam int RM_W    = 2;

  // positions inside the raw exception flag vector (priority order)
  localparam int EX_UNF = 0;
  localparam int EX_OVF = 1;
  localparam int EX_DVZ = 2;
  localparam int EX_INV = 3;
  localparam int EX_INX = 4;
  localparam int EX_N   = 5;

  typedef enum logic [TT_W-1:0] {
    TC_NONE = 3'd0,
    TC_UNF  = 3'd1,
    TC_OVF  = 3'd2,
    TC_DVZ  = 3'd3,
    TC_ILL  = 3'd4,
    TC_INV  = 3'd5,
    TC_INX  = 3'd6
  } trap_code_e;

  typedef struct packed {
    trap_code_e code;
    logic       quit;
    logic       zero;
    logic       set_uf;
    logic       set_if;
  } verdict_t;

endpackage

// File: rtl/fpx_resolver.sv
module fpx_resolver
  import fpx_pkg::*;
(
  input  logic            exc_valid,
  input  logic [EX_N-1:0] flags,
  input  logic            illegal,
  input  logic            unf_en,
  input  logic            inx_en,
  output verdict_t        verdict
);

  // first-present exception wins; only underflow and inexact are maskable
  function automatic verdict_t judge(input logic [EX_N-1:0] f, input logic ill,
                                     input logic uen, input logic ien);
    verdict_t v;
    v = '{code: TC_NONE, quit: 1'b0, zero: 1'b0, set_uf: 1'b0, set_if: 1'b0};
    if (ill) begin
      v.code = TC_ILL;
      v.quit = 1'b1;
    end else if (f[EX_UNF]) begin
      v.code   = TC_UNF;
      v.set_uf = 1'b1;
      v.quit   = uen;
      v.zero   = ~uen;
    end else if (f[EX_OVF]) begin
      v.code = TC_OVF;
      v.quit = 1'b1;
    end else if (f[EX_DVZ]) begin
      v.code = TC_DVZ;
      v.quit = 1'b1;
    end else if (f[EX_INV]) begin
      v.code = TC_INV;
    end else if (f[EX_INX]) begin
      v.code   = TC_INX;
      v.set_if = 1'b1;
      v.quit   = ien;
    end
    return v;
  endfunction

  verdict_t raw;

  always_comb begin
    raw = judge(flags, illegal, unf_en, inx_en);
    if (exc_valid) verdict = raw;
    else           verdict = '{code: TC_NONE, quit: 1'b0, zero: 1'b0, set_uf: 1'b0, set_if: 1'b0};
  end

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [REG_W-1:0] ld_val,
  input  logic             upd_en,
  input  verdict_t         verdict,
  input  logic             clr_tt,
  output logic [REG_W-1:0] stat_q
);

  logic [REG_W-1:0] stat_d;
  logic [REG_W-1:0] tt_mask;

  always_comb begin
    tt_mask = '0;
    tt_mask[TT_LSB +: TT_W] = '1;
  end

  // load beats evaluate, evaluate beats a bare start strobe
  always_comb begin
    stat_d = stat_q;
    if (ld_en) begin
      stat_d = ld_val;
    end else if (upd_en) begin
      stat_d = stat_q & ~tt_mask;
      stat_d[TT_LSB +: TT_W] = verdict.code;
      stat_d[UF_BIT] = stat_q[UF_BIT] | verdict.set_uf;
      stat_d[IF_BIT] = stat_q[IF_BIT] | verdict.set_if;
    end else if (clr_tt) begin
      stat_d = stat_q & ~tt_mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> stat_q == $past(ld_val)); // R12

  AST_UF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && stat_q[UF_BIT]) |=> stat_q[UF_BIT]); // R11

  AST_IF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && stat_q[IF_BIT]) |=> stat_q[IF_BIT]); // R11

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_tt && !ld_en && !upd_en) |=> stat_q[TT_LSB +: TT_W] == '0); // R3

  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> (stat_q[TT_LSB +: TT_W] != 3'd7 || $past(stat_q[TT_LSB +: TT_W]) == 3'd7)); // R4

endmodule

// File: rtl/fpx_status_unit.sv
module fpx_status_unit
  import fpx_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int OPND_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic              exc_valid,
  input  logic [EX_N-1:0]   exc_flags,
  input  logic              illegal,
  input  logic              ld_en,
  input  logic [OPND_W-1:0] ld_data,
  output logic [REG_W-1:0]  status_q,
  output logic [OPND_W-1:0] store_data,
  output logic [RM_W-1:0]   round_mode,
  output logic              quit,
  output logic              suppress,
  output logic              zero_result
);

  localparam int PAD_W = OPND_W - REG_W;

  verdict_t         verdict;
  logic [REG_W-1:0] stat;

  fpx_resolver u_resolve (
    .exc_valid (exc_valid),
    .flags     (exc_flags),
    .illegal   (illegal),
    .unf_en    (stat[UEN_BIT]),
    .inx_en    (stat[IEN_BIT]),
    .verdict   (verdict)
  );

  fpx_status_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ld_en),
    .ld_val  (ld_data[REG_W-1:0]),
    .upd_en  (exc_valid),
    .verdict (verdict),
    .clr_tt  (op_start),
    .stat_q  (stat)
  );

  assign status_q    = stat;
  assign store_data  = {{PAD_W{1'b0}}, stat};
  assign round_mode  = stat[RM_LSB +: RM_W];
  assign quit        = verdict.quit;
  assign suppress    = verdict.quit;
  assign zero_result = verdict.zero;

  AST_OVF_DVZ_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !illegal && !exc_flags[EX_UNF] && (exc_flags[EX_OVF] || exc_flags[EX_DVZ]))
      |-> quit); // R6

  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && !illegal && exc_flags == 5'b01000) |-> (!quit && !zero_result)); // R7

  AST_FLUSH_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    zero_result |-> (!quit && exc_flags[EX_UNF] && !status_q[UEN_BIT])); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_valid |-> (!quit && !suppress && !zero_result)); // R9

  AST_ILLEGAL_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && illegal && !ld_en) |=> (status_q[2:0] == 3'd4
      && status_q[4] == $past(status_q[4]) && status_q[6] == $past(status_q[6]))); // R10

endmodule

// File: tb/fpx_status_unit_tb.sv
module fpx_status_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_start = 1'b0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_flags = '0;
  logic        illegal = 1'b0;
  logic        ld_en = 1'b0;
  logic [31:0] ld_data = '0;
  logic [15:0] status_q;
  logic [31:0] store_data;
  logic [1:0]  round_mode;
  logic        quit, suppress, zero_result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int m_reg  = 0;   // reference status word

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_status_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .exc_valid(exc_valid),
    .exc_flags(exc_flags), .illegal(illegal), .ld_en(ld_en), .ld_data(ld_data),
    .status_q(status_q), .store_data(store_data), .round_mode(round_mode),
    .quit(quit), .suppress(suppress), .zero_result(zero_result)
  );

  function automatic logic [52:0] pack_obs();
    return {status_q, round_mode, quit, suppress, zero_result, store_data};
  endfunction

  task automatic compare(input logic [52:0] exp_v, input string tag);
    logic [52:0] act;
    act = pack_obs();
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // drive one cycle, check at negedge against the model, advance model
  task automatic step(input logic st, input logic ev, input logic [4:0] fl,
                      input logic il, input logic le, input logic [31:0] ld,
                      input string tag);
    int code, q, z, uf, inx, nxt;
    op_start = st; exc_valid = ev; exc_flags = fl; illegal = il;
    ld_en = le; ld_data = ld;
    code = 0; q = 0; z = 0; uf = 0; inx = 0;
    if (ev) begin
      if (il) begin code = 4; q = 1; end
      else if (fl[0]) begin code = 1; uf = 1; if ((m_reg >> 3) & 1) q = 1; else z = 1; end
      else if (fl[1]) begin code = 2; q = 1; end
      else if (fl[2]) begin code = 3; q = 1; end
      else if (fl[3]) code = 5;
      else if (fl[4]) begin code = 6; inx = 1; q = (m_reg >> 5) & 1; end
    end
    @(negedge clk);
    compare({m_reg[15:0], m_reg[8:7], q[0], q[0], z[0], 16'h0000, m_reg[15:0]}, tag);
    nxt = m_reg;
    if (le) nxt = ld[15:0];
    else if (ev) nxt = (m_reg & 'hfff8) | code | (uf << 4) | (inx << 6);
    else if (st) nxt = m_reg & 'hfff8;
    m_reg = nxt;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input string tag);
    step(0, 0, 5'b0, 0, 0, 32'h0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    compare(53'h0, "R1 in reset");
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_reg = 0;
    quiet("R1 after reset");

    // R2: load, upper half dropped, rounding mode and store
    step(0, 0, 5'b0, 0, 1, 32'hABCD_0180, "R2 load upper ignored");
    quiet("R2 round mode 11");
    step(0, 0, 5'b0, 0, 1, 32'h0000_FE80, "R2 scratch field and mode 01");
    quiet("R2 store zero-extended");
    step(0, 0, 5'b0, 0, 1, 32'h0000_0100, "R2 mode 10");
    quiet("R2 mode 10 visible");

    // R5: masked underflow then enabled underflow
    step(0, 0, 5'b0, 0, 1, 32'h0, "R5 clear");
    step(1, 0, 5'b0, 0, 0, 32'h0, "R3 start");
    step(0, 1, 5'b00001, 0, 0, 32'h0, "R5 masked underflow flushes");
    quiet("R5 underflow flag set");
    step(0, 0, 5'b0, 0, 1, 32'h0000_0008, "R5 enable underflow trap");
    step(0, 1, 5'b10011, 0, 0, 32'h0, "R5 enabled underflow traps");
    quiet("R5 code 1 recorded");

    // R3: start clears code only
    step(1, 0, 5'b0, 0, 0, 32'h0, "R3 start clears code");
    quiet("R3 other bits kept");

    // R6, R7, R8
    step(0, 1, 5'b10010, 0, 0, 32'h0, "R6 overflow over inexact");
    step(1, 0, 5'b0, 0, 0, 32'h0, "R3 start");
    step(0, 1, 5'b01100, 0, 0, 32'h0, "R6 divide by zero");
    step(0, 1, 5'b11000, 0, 0, 32'h0, "R7 invalid no trap");
    step(0, 1, 5'b10000, 0, 0, 32'h0, "R8 inexact masked");
    quiet("R8 inexact flag set");
    step(0, 0, 5'b0, 0, 1, 32'h0000_0020, "R8 enable inexact");
    step(0, 1, 5'b10000, 0, 0, 32'h0, "R8 inexact traps");

    // R10: illegal ignores flags and sticky bits
    step(0, 0, 5'b0, 0, 1, 32'h0000_0000, "R10 clear");
    step(0, 1, 5'b11111, 1, 0, 32'h0, "R10 illegal traps");
    quiet("R10 sticky untouched");

    // R11: sticky bits survive clean evaluates and starts
    step(0, 1, 5'b00001, 0, 0, 32'h0, "R11 set uf");
    step(0, 1, 5'b10000, 0, 0, 32'h0, "R11 set if");
    step(1, 0, 5'b0, 0, 0, 32'h0, "R11 start");
    step(0, 1, 5'b00000, 0, 0, 32'h0, "R11 clean evaluate");
    step(0, 1, 5'b00010, 0, 0, 32'h0, "R11 overflow keeps sticky");
    quiet("R11 sticky kept");

    // R12: load collides with evaluate and start
    step(1, 1, 5'b00010, 0, 1, 32'h0000_1234, "R12 load wins");
    quiet("R12 loaded value");

    // R9: flags without evaluate do nothing
    step(0, 0, 5'b11111, 1, 0, 32'h0, "R9 idle flags quiet");
    quiet("R9 word unchanged");

    // R4: exhaustive flags under each enable pair
    for (int en = 0; en < 4; en++) begin
      for (int f = 0; f < 32; f++) begin
        step(0, 0, 5'b0, 0, 1, 32'h0000_0000 | ((en & 1) << 3) | ((en >> 1) << 5), "R4 setup");
        step(0, 1, f[4:0], 0, 0, 32'h0, "R4 priority");
        quiet("R4 code recorded");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule